// File: doc/BRIEF.md
# Expansion-Card Configuration Base Latch

This block sits at the front of an expansion card on a 24-bit, byte-wide CPU bus. Out of reset the card is unconfigured. It answers at a fixed configuration base, the upper address byte `CFG_BASE` (default `0xE8`). There it presents its identity as a table of 4-bit configuration nibbles. Host software assigns the card's final location in two steps:

- It pre-writes the low nibble of the new base to window offset `0x004A`.
- It commits the whole byte by a write to window offset `0x0048`.

From the commit onward, the card's 64 KiB window answers only at the assigned base.

The block also classifies each selected access into a region of the card's local map. That map is active whether or not the card is configured. A downstream device-select, clock-port, register or ROM path can use the region and the device index directly. The configuration table is a parameter, so no storage is needed for it.

The bus is a plain strobe interface. An access is one clock with `as_i` high. A selected write takes effect at the clock edge that ends that cycle. There is no back-pressure: the block accepts every access in the cycle it is presented.

Top module: `xcfg_base_latch`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `cfg_done_o` is 0 and `base_o` is `0x00`. The card then answers at `CFG_BASE`. A later reset returns it to this state.
- R2: `card_sel_o` is 1 exactly when `as_i` is 1 and `addr_i[23:16]` equals the active base. The active base is `CFG_BASE` while unconfigured and `base_o` once configured.
- R3: A selected write to window offset `0x004A` while unconfigured works as follows:
  - `base_o[3:0]` takes `wdata_i[7:4]` and `base_o[7:4]` is unchanged.
  - `cfg_done_o` stays 0.
  - Repeating the write only rewrites that nibble.
- R4: A selected write to window offset `0x0048` while unconfigured makes `base_o` equal to `wdata_i` and sets `cfg_done_o` to 1. From the next cycle the card answers at the new base and no longer at `CFG_BASE`.
- R5: Once configured, `base_o` and `cfg_done_o` hold until reset. This includes writes to window offsets `0x0048` and `0x004A` at the new base.
- R6: A selected read with window offset below `0x0080` returns configuration nibble `n = offset[6:1]` in `rdata_o[7:4]`, with `rdata_o[3:0] = 0`. Nibble `n` is `CFG_TABLE[4n+3:4n]`. Every other cycle returns `rdata_o = 0x00`.
- R7: `region_o` encodes the region of a selected access. The codes are:
  - 1: configuration, offsets `0x0000`–`0x007F`
  - 2: reserved, `0x0080`–`0x07FF`
  - 3: device select, `0x0800`–`0x0DFF`
  - 4: clock port, `0x0E00`–`0x0EFF`
  - 5: control registers, `0x0F00`–`0x0FFF`
  - 6: ROM
  - 0: no region, including every cycle with `card_sel_o` low.
- R8: For the device-select region, `dev_idx_o` is `(offset - 0x0800) / 256`, a value from 0 to 5. In all other cases it is 0.
- R9: The ROM region covers even offsets from `0x1000` to `0xFFFE` only. An odd offset in that range gives region 0.
- R10: Writes to any other offset, and reads of `0x0048` or `0x004A`, leave `base_o` and `cfg_done_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_i | input | 1 | Address strobe; an access is one cycle with this high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Configuration nibble in bits 7:4, zero otherwise |
| cfg_done_o | output | 1 | Card has been assigned a base |
| base_o | output | 8 | Latched base (staged nibble before commit) |
| card_sel_o | output | 1 | Access falls in the card's active 64 KiB window |
| region_o | output | 3 | Local-map region code (R7) |
| dev_idx_o | output | 3 | Device-select index 0..5 (R8) |

## Verification
Reads are tried at even and odd configuration offsets, at one offset in each map region and at both edges of the ROM range. This separates nibble indexing from region slicing. Pre-writes of different nibbles, followed by a commit whose low nibble differs from the staged one, show whether the commit takes the full byte. Accesses at the old base, the new base and a foreign base, with and without the strobe, show whether the card has relocated. Writes at the relocated card's base-register offsets and a reset after configuration cover the hold behaviour and the return to the unconfigured state.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;
  localparam int DATA_W = 8;
  localparam int WIN_W  = 16;
  localparam int BASE_W = 8;
  localparam int ADDR_W = BASE_W + WIN_W;

  localparam logic [WIN_W-1:0] OFS_PRE    = 16'h004A;
  localparam logic [WIN_W-1:0] OFS_COMMIT = 16'h0048;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_CFG  = 3'd1,
    RG_RSVD = 3'd2,
    RG_DEV  = 3'd3,
    RG_CLK  = 3'd4,
    RG_CTRL = 3'd5,
    RG_ROM  = 3'd6
  } region_e;
endpackage

// File: rtl/xcfg_win_decode.sv
module xcfg_win_decode
  import xcfg_pkg::*;
(
  input  logic             sel_i,
  input  logic [WIN_W-1:0] ofs_i,
  output region_e          region_o,
  output logic [2:0]       dev_idx_o
);
  logic [2:0] hi_blk;
  logic       unused_ofs;

  assign hi_blk     = ofs_i[10:8];
  assign unused_ofs = ^ofs_i[6:1];

  always_comb begin
    region_o  = RG_NONE;
    dev_idx_o = 3'd0;
    if (sel_i) begin
      if (ofs_i[15:12] != 4'h0) begin
        region_o = ofs_i[0] ? RG_NONE : RG_ROM;
      end else if (ofs_i[11]) begin
        if (hi_blk == 3'd7) begin
          region_o = RG_CTRL;
        end else if (hi_blk == 3'd6) begin
          region_o = RG_CLK;
        end else begin
          region_o  = RG_DEV;
          dev_idx_o = hi_blk;
        end
      end else if (ofs_i[10:7] == 4'h0) begin
        region_o = RG_CFG;
      end else begin
        region_o = RG_RSVD;
      end
    end
  end
endmodule

// File: rtl/xcfg_nib_rom.sv
module xcfg_nib_rom #(
  parameter int                NIB_N = 64,
  parameter logic [NIB_N*4-1:0] TABLE = '0,
  localparam int               IDX_W = $clog2(NIB_N)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [3:0]       nib_o
);
  logic [3:0] nib_arr [NIB_N];

  for (genvar i = 0; i < NIB_N; i++) begin : g_nib
    assign nib_arr[i] = TABLE[4*i +: 4];
  end

  assign nib_o = nib_arr[idx_i];
endmodule

// File: rtl/xcfg_base_reg.sv
module xcfg_base_reg
  import xcfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pre_wr_i,
  input  logic              commit_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              cfg_done_o,
  output logic [BASE_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_done_o <= 1'b0;
      base_o     <= '0;
    end else if (!cfg_done_o) begin
      if (commit_wr_i) begin
        base_o     <= wdata_i;
        cfg_done_o <= 1'b1;
      end else if (pre_wr_i) begin
        base_o[3:0] <= wdata_i[7:4];
      end
    end
  end
endmodule

// File: rtl/xcfg_base_latch.sv
module xcfg_base_latch
  import xcfg_pkg::*;
#(
  parameter logic [7:0]         CFG_BASE  = 8'hE8,
  parameter int                 NIB_N     = 64,
  parameter logic [NIB_N*4-1:0] CFG_TABLE = 256'h0123456789ABCDEFFEDCBA987654321013579BDF02468ACEF0E1D2C3B4A59687
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        as_i,
  input  logic        we_i,
  input  logic [23:0] addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        cfg_done_o,
  output logic [7:0]  base_o,
  output logic        card_sel_o,
  output logic [2:0]  region_o,
  output logic [2:0]  dev_idx_o
);
  localparam int IDX_W = $clog2(NIB_N);

  logic [BASE_W-1:0] active_base;
  logic [WIN_W-1:0]  ofs;
  logic              wr_hit;
  logic              pre_wr;
  logic              commit_wr;
  region_e           region;
  logic [3:0]        nib;

  assign active_base = cfg_done_o ? base_o : CFG_BASE;
  assign card_sel_o  = as_i && (addr_i[ADDR_W-1:WIN_W] == active_base);
  assign ofs         = addr_i[WIN_W-1:0];
  assign wr_hit      = card_sel_o && we_i;
  assign pre_wr      = wr_hit && (ofs == OFS_PRE);
  assign commit_wr   = wr_hit && (ofs == OFS_COMMIT);

  xcfg_base_reg u_base (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pre_wr_i    (pre_wr),
    .commit_wr_i (commit_wr),
    .wdata_i     (wdata_i),
    .cfg_done_o  (cfg_done_o),
    .base_o      (base_o)
  );

  xcfg_win_decode u_dec (
    .sel_i     (card_sel_o),
    .ofs_i     (ofs),
    .region_o  (region),
    .dev_idx_o (dev_idx_o)
  );

  xcfg_nib_rom #(.NIB_N(NIB_N), .TABLE(CFG_TABLE)) u_rom (
    .idx_i (ofs[IDX_W:1]),
    .nib_o (nib)
  );

  assign region_o = region;
  assign rdata_o  = (region == RG_CFG && !we_i) ? {nib, 4'h0} : 8'h00;
endmodule

// File: rtl/xcfg_base_latch_chk.sv
module xcfg_base_latch_chk #(
  parameter logic [7:0] CFG_BASE = 8'hE8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        as_i,
  input logic        we_i,
  input logic [23:0] addr_i,
  input logic [7:0]  wdata_i,
  input logic        cfg_done_o,
  input logic [7:0]  base_o,
  input logic        card_sel_o,
  input logic [2:0]  region_o
);
  logic at_cfg_wr;
  assign at_cfg_wr = as_i && we_i && !cfg_done_o && addr_i[23:16] == CFG_BASE;

  // R2
  sel_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_sel_o |-> as_i);

  // R2
  unconf_at_cfg_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_sel_o && !cfg_done_o) |-> addr_i[23:16] == CFG_BASE);

  // R3
  pre_nibble_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_cfg_wr && addr_i[15:0] == 16'h004A) |=>
      (!cfg_done_o && base_o[3:0] == $past(wdata_i[7:4]) && base_o[7:4] == $past(base_o[7:4])));

  // R4
  commit_full_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_cfg_wr && addr_i[15:0] == 16'h0048) |=> (cfg_done_o && base_o == $past(wdata_i)));

  // R5
  hold_after_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |=> (cfg_done_o && $stable(base_o)));

  // R9
  rom_even_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o == 3'd6) |-> !addr_i[0]);
endmodule

bind xcfg_base_latch xcfg_base_latch_chk #(.CFG_BASE(CFG_BASE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .as_i       (as_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .cfg_done_o (cfg_done_o),
  .base_o     (base_o),
  .card_sel_o (card_sel_o),
  .region_o   (region_o)
);

// File: tb/xcfg_base_latch_tb.sv
module xcfg_base_latch_tb;
  localparam logic [255:0] TB_TAB =
    256'hC0FFEE1234567890ABCDEF0011223344556677889900AABBCCDDEEFF5A5AA5A5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        as_i = 1'b0;
  logic        we_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        cfg_done_o;
  logic [7:0]  base_o;
  logic        card_sel_o;
  logic [2:0]  region_o;
  logic [2:0]  dev_idx_o;

  int n_tests = 0;
  int n_fail  = 0;
  int m_cfg   = 0;
  int m_base  = 0;

  always #10 clk_i = ~clk_i;

  xcfg_base_latch #(.CFG_TABLE(TB_TAB)) u_dut (.*);

  task automatic chk(input int act, input int exp, input string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_region(input int off);
    if (off >= 'h1000) return (off % 2 == 0) ? 6 : 0;
    if (off >= 'hF00) return 5;
    if (off >= 'hE00) return 4;
    if (off >= 'h800) return 3;
    if (off >= 'h80) return 2;
    return 1;
  endfunction

  task automatic cyc(input bit as, input bit we, input int a, input int d);
    int off, sel, rg;
    @(negedge clk_i);
    as_i = as; we_i = we; addr_i = a[23:0]; wdata_i = d[7:0];
    #5;
    off = a & 'hFFFF;
    sel = (as && ((a >> 16) & 'hFF) == (m_cfg != 0 ? m_base : 'hE8)) ? 1 : 0;
    rg  = sel ? exp_region(off) : 0;
    chk(card_sel_o, sel, "R2 card_sel");
    chk(region_o, rg, "R7/R9 region");
    chk(dev_idx_o, (rg == 3) ? (off - 'h800) / 256 : 0, "R8 dev_idx");
    chk(rdata_o, (rg == 1 && !we) ? ((TB_TAB >> (4 * (off / 2))) & 'hF) * 16 : 0, "R6 rdata");
    @(posedge clk_i);
    if (sel && we && m_cfg == 0) begin
      if (off == 'h48) begin m_base = d & 'hFF; m_cfg = 1; end
      else if (off == 'h4A) m_base = (m_base & 'hF0) | ((d >> 4) & 'hF);
    end
    #1;
    chk(cfg_done_o, m_cfg, "R4/R5/R10 cfg_done");
    chk(base_o, m_base, "R3/R5/R10 base");
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    as_i = 0; rst_ni = 0; m_cfg = 0; m_base = 0;
    #3;
    chk(cfg_done_o, 0, "R1 cfg_done in reset");
    chk(base_o, 0, "R1 base in reset");
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1: answers at configuration base after reset
    cyc(1, 0, 'hE80000, 0);
    // R6: nibble reads, even and odd offsets
    for (int i = 0; i < 8; i++) cyc(1, 0, 'hE80000 + i * 18, 0);
    cyc(1, 0, 'hE8007E, 0);
    cyc(1, 0, 'hE8007F, 0);
    // R7 R8 R9: region map
    cyc(1, 0, 'hE80080, 0);
    cyc(1, 0, 'hE807FF, 0);
    for (int i = 0; i < 6; i++) cyc(1, 0, 'hE80800 + i * 'h100 + 'h44, 0);
    cyc(1, 0, 'hE80E10, 0);
    cyc(1, 0, 'hE80F42, 0);
    cyc(1, 0, 'hE81000, 0);
    cyc(1, 0, 'hE81001, 0);
    cyc(1, 0, 'hE8FFFE, 0);
    cyc(1, 0, 'hE80FFF, 0);
    // R2: no strobe, foreign base
    cyc(0, 0, 'hE80000, 0);
    cyc(1, 0, 'h200000, 0);
    // R10: writes elsewhere, reads of base offsets
    cyc(1, 1, 'hE8004C, 'hA5);
    cyc(1, 1, 'hE80049, 'hA5);
    cyc(1, 0, 'hE80048, 0);
    cyc(1, 0, 'hE8004A, 0);
    cyc(1, 1, 'hE80F42, 'h60);
    // R3: repeated pre-writes
    cyc(1, 1, 'hE8004A, 'h30);
    cyc(1, 1, 'hE8004A, 'h5F);
    cyc(1, 1, 'hE8004A, 'h50);
    cyc(0, 1, 'hE8004A, 'h90);
    cyc(1, 0, 'hE80002, 0);
    // R4: commit
    cyc(1, 1, 'hE80048, 'h20);
    cyc(1, 0, 'hE80002, 0);
    cyc(1, 0, 'h200002, 0);
    cyc(1, 0, 'h200A00, 0);
    // R5: base writes after configuration
    cyc(1, 1, 'h200048, 'h40);
    cyc(1, 1, 'h20004A, 'h70);
    cyc(1, 1, 'hE80048, 'h40);
    cyc(1, 0, 'h200000, 0);
    // R1: reset after configuration
    do_reset();
    cyc(1, 0, 'h200000, 0);
    cyc(1, 0, 'hE80004, 0);
    // R4: commit overrides staged nibble
    cyc(1, 1, 'hE8004A, 'h70);
    cyc(1, 1, 'hE80048, 'h9C);
    cyc(1, 0, 'h9C0E00, 0);
    cyc(1, 0, 'hE80E00, 0);
    @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule